// File: doc/BRIEF.md
# MDIO Management Clock Generator

This block derives the management data clock (MDC) for an MDIO interface from the peripheral clock. A 3-bit code picks one of eight divide ratios, 8, 16, 32, 48, 64, 96, 128 or 224. Software picks the code so that MDC stays at or below 2.5 MHz for the pclk frequency in use. For example, divide-by-48 suits a pclk of up to 120 MHz.

MDC toggles only while `mdio_busy` marks a read or write transfer as in progress. Between transfers it rests low. Alongside MDC the block gives two single-cycle strobes, one on the pclk edge where MDC rises and one where it falls. A neighbouring MDIO shifter uses them to launch and capture serial data without a second clock domain.

The code in use is latched only at the boundary between MDC periods. A new setting therefore never cuts a high or low phase short. The latched code survives idle gaps, and after reset it holds a parameterised default code.

Top module: `mdc_clkgen`

## Requirements
- R1: Reset behaviour. While `rst` is high and on the first cycle after it, `mdc`, `mdc_rise` and `mdc_fall` are 0. The latched divisor code resets to parameter `RST_CODE` (default 3'b011, divide by 48).
- R2: Code table. The latched code selects the divide ratio N. 3'b000 gives 8, 3'b001 gives 16, 3'b010 gives 32 and 3'b011 gives 48. 3'b100 gives 64, 3'b101 gives 96, 3'b110 gives 128 and 3'b111 gives 224.
- R3: Duty cycle. During a transfer, each MDC period lasts N pclk cycles: MDC is high for N/2 cycles and then low for N/2 cycles.
- R4: Idle low. On any pclk edge where `mdio_busy` is sampled low, MDC goes low (or stays low). No rising strobe is produced while idle. If MDC was high, `mdc_fall` pulses once.
- R5: Transfer start. On the first edge where `mdio_busy` is sampled high after it was low, MDC rises and the period counter restarts from zero. The first period is therefore full length.
- R6: Boundary latching. `div_code` is sampled only on an edge that ends an MDC period during a transfer. Only the value present on that edge matters. A change made mid-period, or while idle, does not alter the period in progress. The first period of the first transfer after reset uses `RST_CODE`.
- R7: Strobes. `mdc_rise` is high for exactly the one cycle in which MDC first reads high, and `mdc_fall` for exactly the one cycle in which MDC first reads low. The two strobes are never high together.
- R8: No short phase. When MDC falls while the transfer continues, the preceding high phase lasted at least 4 pclk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock (pclk) |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 3 | Divide-ratio code, latched at MDC period boundaries |
| mdio_busy | input | 1 | High while a management read or write is in progress |
| mdc | output | 1 | Management data clock, registered |
| mdc_rise | output | 1 | One-cycle strobe in the cycle MDC becomes high |
| mdc_fall | output | 1 | One-cycle strobe in the cycle MDC becomes low |

## Verification
The assertions assume that `mdio_busy` and `div_code` are synchronous to pclk and settle well before each rising edge. The bench keeps to this by changing inputs only on the falling edge. The minimum-high-phase property is checked only for falls that happen while the transfer continues, because dropping `mdio_busy` ends a high phase at whatever point it has reached. The stimulus ends transfers mid-phase on purpose and re-arms them, so this exemption is exercised. Code changes are made mid-period, several times within one period, and while idle, so that boundary latching is tested against the values that arrive too early.

// File: rtl/mdc_clkgen_pkg.sv
package mdc_clkgen_pkg;

  localparam int CODE_W = 3;
  localparam int DIV_W  = 8;

  typedef logic [CODE_W-1:0] div_code_t;
  typedef logic [DIV_W-1:0]  div_cnt_t;

  // Ratio table: powers of two for low codes, mixed steps above.
  function automatic div_cnt_t divisor_of(input div_code_t code);
    div_cnt_t n;
    case (code)
      3'd0:    n = 8'd8;
      3'd1:    n = 8'd16;
      3'd2:    n = 8'd32;
      3'd3:    n = 8'd48;
      3'd4:    n = 8'd64;
      3'd5:    n = 8'd96;
      3'd6:    n = 8'd128;
      default: n = 8'd224;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mdc_code_hold.sv
module mdc_code_hold
  import mdc_clkgen_pkg::*;
#(
  parameter div_code_t RST_CODE = 3'd3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  div_code_t code_in,
  output div_cnt_t  half_o,
  output div_cnt_t  last_o
);

  div_code_t code_q;
  div_cnt_t  full_n;

  // Latched code; only reloaded on a period boundary.
  always_ff @(posedge clk) begin
    if (rst)       code_q <= RST_CODE;
    else if (load) code_q <= code_in;
  end

  always_comb begin
    full_n = divisor_of(code_q);
    half_o = full_n >> 1;
    last_o = full_n - div_cnt_t'(1);
  end

endmodule

// File: rtl/mdc_phase_cnt.sv
module mdc_phase_cnt
  import mdc_clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     run,
  input  div_cnt_t last_i,
  output div_cnt_t cnt_nxt_o,
  output logic     wrap_o
);

  div_cnt_t cnt_q;

  assign wrap_o = run && (cnt_q == last_i);

  always_comb begin
    if (start)       cnt_nxt_o = '0;
    else if (run)    cnt_nxt_o = wrap_o ? '0 : cnt_q + div_cnt_t'(1);
    else             cnt_nxt_o = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt_o;
  end

endmodule

// File: rtl/mdc_edge_out.sv
module mdc_edge_out
  import mdc_clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     busy,
  input  logic     start,
  input  div_cnt_t cnt_nxt,
  input  div_cnt_t half_i,
  output logic     mdc_o,
  output logic     rise_o,
  output logic     fall_o
);

  logic mdc_d;

  always_comb begin
    if (!busy)      mdc_d = 1'b0;
    else if (start) mdc_d = 1'b1;
    else            mdc_d = (cnt_nxt < half_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_o  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      mdc_o  <= mdc_d;
      rise_o <= mdc_d & ~mdc_o;
      fall_o <= ~mdc_d & mdc_o;
    end
  end

endmodule

// File: rtl/mdc_clkgen.sv
module mdc_clkgen
  import mdc_clkgen_pkg::*;
#(
  parameter div_code_t RST_CODE = 3'd3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CODE_W-1:0] div_code,
  input  logic             mdio_busy,
  output logic             mdc,
  output logic             mdc_rise,
  output logic             mdc_fall
);

  logic     busy_q;
  logic     start;
  logic     run;
  logic     wrap;
  div_cnt_t half_n;
  div_cnt_t last_n;
  div_cnt_t cnt_nxt;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= mdio_busy;
  end

  assign start = mdio_busy & ~busy_q;
  assign run   = mdio_busy & busy_q;

  mdc_code_hold #(.RST_CODE(RST_CODE)) code_i (
    .clk     (clk),
    .rst     (rst),
    .load    (wrap),
    .code_in (div_code),
    .half_o  (half_n),
    .last_o  (last_n)
  );

  mdc_phase_cnt cnt_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .run       (run),
    .last_i    (last_n),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  mdc_edge_out out_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (mdio_busy),
    .start   (start),
    .cnt_nxt (cnt_nxt),
    .half_i  (half_n),
    .mdc_o   (mdc),
    .rise_o  (mdc_rise),
    .fall_o  (mdc_fall)
  );

endmodule

// File: rtl/mdc_clkgen_chk.sv
module mdc_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic mdio_busy,
  input logic mdc,
  input logic mdc_rise,
  input logic mdc_fall
);

  logic [7:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)                 hi_len <= '0;
    else if (!mdc)           hi_len <= '0;
    else if (hi_len != 8'hff) hi_len <= hi_len + 8'd1;
  end

  // R4: an idle sample forces MDC low with no rising strobe
  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    !mdio_busy |=> (!mdc && !mdc_rise));

  // R5: first busy sample starts a period with a rising edge
  a_r5_start_rise: assert property (@(posedge clk) disable iff (rst)
    (mdio_busy && !$past(mdio_busy)) |=> (mdc && mdc_rise));

  // R7: strobes never coincide
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mdc_rise && mdc_fall));

  // R7: rise strobe only with MDC high, fall strobe only with MDC low
  a_r7_strobe_level: assert property (@(posedge clk) disable iff (rst)
    (mdc_rise |-> mdc) and (mdc_fall |-> !mdc));

  // R8: a fall inside a transfer follows at least four high cycles
  a_r8_min_high: assert property (@(posedge clk) disable iff (rst)
    (mdc_fall && $past(mdio_busy)) |-> (hi_len >= 8'd4));

endmodule

bind mdc_clkgen mdc_clkgen_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .mdio_busy (mdio_busy),
  .mdc       (mdc),
  .mdc_rise  (mdc_rise),
  .mdc_fall  (mdc_fall)
);

// File: tb/mdc_clkgen_tb_top.sv
module mdc_clkgen_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] div_code;
  logic       mdio_busy;
  logic       mdc, mdc_rise, mdc_fall;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  mdc_clkgen dut_i (
    .clk       (clk),
    .rst       (rst),
    .div_code  (div_code),
    .mdio_busy (mdio_busy),
    .mdc       (mdc),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall)
  );

  function automatic int ratio(input int c);
    if (c < 3)       return 8 << c;
    else if (c == 3) return 48;
    else if (c == 4) return 64;
    else if (c == 5) return 96;
    else if (c == 6) return 128;
    else             return 224;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered on the negedge where MDC first reads high; returns on the next such negedge.
  task automatic measure(input int exp_n, input string req);
    int hi = 0;
    int lo = 0;
    int strobe_err = 0;
    while (mdc === 1'b1 && hi < 1000) begin
      if ((hi == 0) != (mdc_rise === 1'b1)) strobe_err++;
      if (mdc_fall !== 1'b0) strobe_err++;
      hi++;
      @(negedge clk);
    end
    while (mdc === 1'b0 && lo < 1000) begin
      if ((lo == 0) != (mdc_fall === 1'b1)) strobe_err++;
      if (mdc_rise !== 1'b0) strobe_err++;
      lo++;
      @(negedge clk);
    end
    if (mdc_rise !== 1'b1) strobe_err++;
    check(hi == exp_n / 2, {req, " R3 high phase"}, hi, exp_n / 2);
    check(lo == exp_n / 2, {req, " R3 low phase"}, lo, exp_n / 2);
    check(strobe_err == 0, "R7 strobe placement", strobe_err, 0);
  endtask

  initial begin
    rst = 1'b1; mdio_busy = 1'b0; div_code = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mdc === 1'b0 && mdc_rise === 1'b0 && mdc_fall === 1'b0, "R1 reset outputs", mdc, 0);
    rst = 1'b0;
    @(negedge clk);
    check(mdc === 1'b0 && mdc_rise === 1'b0, "R1 idle after reset", mdc, 0);

    // First transfer: reset code (48) then input code 0 (8).
    mdio_busy = 1'b1;
    @(negedge clk);
    check(mdc === 1'b1 && mdc_rise === 1'b1, "R5 start rise", mdc, 1);
    measure(48, "R1 R6 reset code");
    measure(ratio(0), "R2 R6 code0");

    // Sweep every code; each takes effect one period after it is presented.
    for (int c = 1; c < 8; c++) begin
      div_code = 3'(c);
      measure(ratio(c - 1), "R2 R6 old code");
    end
    measure(ratio(7), "R2 code7");

    // Several changes inside one period: only the value at the boundary counts.
    fork
      measure(224, "R6 mid-period change");
      begin
        div_code = 3'd0;
        repeat (50) @(negedge clk);
        div_code = 3'd5;
      end
    join
    measure(96, "R6 boundary value");

    // Drop busy during the high phase, then idle with a new code pending.
    repeat (10) @(negedge clk);
    mdio_busy = 1'b0;
    @(negedge clk);
    check(mdc === 1'b0 && mdc_fall === 1'b1, "R4 drop forces low", mdc, 0);
    div_code = 3'd1;
    begin
      int idle_err = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (mdc !== 1'b0 || mdc_rise !== 1'b0 || mdc_fall !== 1'b0) idle_err++;
      end
      check(idle_err == 0, "R4 idle quiet", idle_err, 0);
    end

    // Restart: full first period with the held code, then the new one.
    mdio_busy = 1'b1;
    @(negedge clk);
    check(mdc === 1'b1 && mdc_rise === 1'b1, "R5 restart rise", mdc, 1);
    measure(96, "R5 R6 held code");
    measure(16, "R2 R6 code1");

    // Drop during the low phase: no strobe at all.
    repeat (10) @(negedge clk);
    mdio_busy = 1'b0;
    @(negedge clk);
    check(mdc === 1'b0 && mdc_fall === 1'b0 && mdc_rise === 1'b0, "R4 drop in low phase", mdc, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule